// File: doc/BRIEF.md
# Transmit FIS Framer

This block builds the outgoing frame stream that a SATA host controller hands to its transport layer. A sequencer picks one of two jobs. The first is a five-dword register host-to-device frame built from a latched opcode selector, 48-bit sector address and 16-bit sector count. The second is a data phase of a given number of dwords, pulled from a transmit FIFO and wrapped into Data frames. Each Data frame opens with a single header dword and carries at most `MAX_PAY` payload dwords. A long write is cut into as many frames as it needs, and the last frame holds the remainder.

The link side is a 32-bit bus with active-low valid (`txSrcRdyN`), ready (`txDstRdyN`) and last-dword (`txEofN`) strobes, plus an abort output that is tied inactive. The FIFO side has an empty flag and a read strobe, and read data shows up one clock after the strobe. A two-entry staging buffer sits between the FIFO and the bus. Reads are issued only while the FIFO reports data and the buffer has room, so an empty FIFO and a stalled link can each pause the stream on any cycle without losing or repeating a dword.

Top module: `fis_tx_framer`

## Requirements
- R1: While `rstN` is low at a clock edge, and in the cycle after it, `busy`, `done` and `fifoRdEn` are 0 and `txSrcRdyN` and `txEofN` are 1.
- R2: `txSrcDscN` is 1 at all times.
- R3: A command request produces exactly 5 dwords. Dword 0 = {8'h00, opcode, 8'h80, 8'h27}, where the opcode is 8'hEC, 8'hF4, 8'h35 or 8'h25 for `cmdOp` 0, 1, 2 or 3. Dword 1 = {8'h40, LBA[23:0]}. Dword 2 = {8'h00, LBA[47:24]}. Dword 3 = {16'h0000, count}. Dword 4 = 0.
- R4: Every Data frame begins with the header dword 32'h0000_0046, followed by payload dwords in the order the FIFO delivered them.
- R5: A data request of N dwords yields ceil(N / `MAX_PAY`) frames. All frames but the last carry exactly `MAX_PAY` payload dwords, and the total number of accepted dwords is N plus the frame count.
- R6: `txEofN` is low on the last dword of every frame, and only when `txSrcRdyN` is low.
- R7: `fifoRdEn` is never high in a cycle where `fifoEmpty` is high. A word read one cycle is taken from `fifoRdData` the next cycle, and never more than two words are held or in flight.
- R8: While `txSrcRdyN` is low and `txDstRdyN` is high, the next cycle still has `txSrcRdyN` low, with the same `txData` and `txEofN`.
- R9: `busy` is high from the cycle after an accepted request until the job ends. `done` pulses for one cycle, in the cycle after the final dword is accepted. Requests made while `busy` is high are ignored.
- R10: A data request with `dataLen` = 0 is ignored. When `sendCmd` and `sendData` are both high while idle, only the command frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| sendCmd | input | 1 | Start a command frame (taken when idle) |
| cmdOp | input | 2 | Command selector: 0 identify, 1 secure erase, 2 DMA write, 3 DMA read |
| cmdLba | input | 48 | Starting sector address |
| cmdCount | input | 16 | Sector count |
| sendData | input | 1 | Start a data phase (taken when idle) |
| dataLen | input | LEN_W | Payload length of the data phase in dwords |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse when a job ends |
| fifoEmpty | input | 1 | Transmit FIFO has no word to give |
| fifoRdEn | output | 1 | Transmit FIFO read strobe |
| fifoRdData | input | 32 | FIFO word, valid one clock after the strobe |
| txData | output | 32 | Outgoing dword |
| txEofN | output | 1 | Last dword of frame, active low |
| txSrcRdyN | output | 1 | Outgoing dword valid, active low |
| txSrcDscN | output | 1 | Abort toward transport, held at 1 |
| txDstRdyN | input | 1 | Transport ready, active low |

## Verification
The hard case is a cycle in which a staged dword leaves on the bus while a FIFO word lands in the staging buffer and a new read is issued. The same cycle may also see an empty FIFO or a stalled link. Each table vector sets its own per-cycle probabilities for `fifoEmpty` and `txDstRdyN`, drawn from a free-running LFSR, so pops, pushes, reads, gaps and stalls overlap in many combinations across frame boundaries. Every accepted dword is compared with an expected stream built from the requirements. Every stalled cycle is checked for an unchanged dword on the following cycle.

// File: rtl/fis_tx_pkg.sv
package fis_tx_pkg;

  localparam int DWORD_W = 32;
  localparam int LBA_W   = 48;
  localparam int CNT_W   = 16;
  localparam int CMD_DWORDS = 5;

  localparam logic [7:0] FIS_TYPE_H2D  = 8'h27;
  localparam logic [7:0] FIS_TYPE_DATA = 8'h46;
  localparam logic [7:0] H2D_CMD_FLAG  = 8'h80;
  localparam logic [7:0] DEV_LBA_MODE  = 8'h40;

  typedef enum logic [1:0] {
    SRC_CMD = 2'd0,
    SRC_HDR = 2'd1,
    SRC_PAY = 2'd2
  } srcSel_e;

  typedef struct packed {
    logic    latchCmd;
    srcSel_e srcSel;
    logic [2:0] cmdIdx;
    logic    push;
    logic    pop;
  } ctrlStrobes_t;

  function automatic logic [7:0] ataOpcode(input logic [1:0] op);
    case (op)
      2'd0:    return 8'hEC;
      2'd1:    return 8'hF4;
      2'd2:    return 8'h35;
      default: return 8'h25;
    endcase
  endfunction

endpackage

// File: rtl/fis_tx_dpath.sv
module fis_tx_dpath
  import fis_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strb,
  input  logic [1:0]           cmdOp,
  input  logic [LBA_W-1:0]     cmdLba,
  input  logic [CNT_W-1:0]     cmdCount,
  input  logic [DWORD_W-1:0]   fifoRdData,
  output logic [DWORD_W-1:0]   txData,
  output logic [1:0]           bufCount
);

  logic [1:0]         opQ;
  logic [LBA_W-1:0]   lbaQ;
  logic [CNT_W-1:0]   cntQ;
  logic [DWORD_W-1:0] stage0, stage1;
  logic [1:0]         occ;

  assign bufCount = occ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ  <= '0;
      lbaQ <= '0;
      cntQ <= '0;
    end else if (strb.latchCmd) begin
      opQ  <= cmdOp;
      lbaQ <= cmdLba;
      cntQ <= cmdCount;
    end
  end

  // two-entry staging buffer, stage0 is the head
  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ    <= '0;
      stage0 <= '0;
      stage1 <= '0;
    end else begin
      unique case ({strb.push, strb.pop})
        2'b10: begin
          if (occ == 2'd0) stage0 <= fifoRdData;
          else             stage1 <= fifoRdData;
          occ <= occ + 2'd1;
        end
        2'b01: begin
          stage0 <= stage1;
          occ    <= occ - 2'd1;
        end
        2'b11: begin
          if (occ == 2'd1) stage0 <= fifoRdData;
          else begin
            stage0 <= stage1;
            stage1 <= fifoRdData;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    txData = '0;
    unique case (strb.srcSel)
      SRC_CMD: begin
        unique case (strb.cmdIdx)
          3'd0:    txData = {8'h00, ataOpcode(opQ), H2D_CMD_FLAG, FIS_TYPE_H2D};
          3'd1:    txData = {DEV_LBA_MODE, lbaQ[23:0]};
          3'd2:    txData = {8'h00, lbaQ[47:24]};
          3'd3:    txData = {16'h0000, cntQ};
          default: txData = '0;
        endcase
      end
      SRC_HDR: txData = {24'h000000, FIS_TYPE_DATA};
      default: txData = stage0;
    endcase
  end

  // R7: a landing word always finds a free slot
  assert_buf_room_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && occ == 2'd2) |-> strb.pop);
  // R7: nothing is popped from an empty buffer
  assert_pop_nonempty_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> (occ != 2'd0));

endmodule

// File: rtl/fis_tx_ctrl.sv
module fis_tx_ctrl
  import fis_tx_pkg::*;
#(
  parameter int MAX_PAY = 2048,
  parameter int LEN_W   = 24
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sendCmd,
  input  logic             sendData,
  input  logic [LEN_W-1:0] dataLen,
  input  logic             fifoEmpty,
  input  logic             txDstRdyN,
  input  logic [1:0]       bufCount,
  output ctrlStrobes_t     strb,
  output logic             fifoRdEn,
  output logic             txSrcRdyN,
  output logic             txEofN,
  output logic             busy,
  output logic             done
);

  localparam int PAY_W = $clog2(MAX_PAY + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_HDR, ST_PAY} state_e;

  state_e           state;
  logic [2:0]       cmdIdx;
  logic [LEN_W-1:0] totLeft;
  logic [PAY_W-1:0] frameLeft, reqLeft;
  logic             inflight, doneQ;
  logic             valid, eof, acc, pop;
  logic [2:0]       occ;

  function automatic logic [PAY_W-1:0] frameSize(input logic [LEN_W-1:0] rem);
    return (rem > LEN_W'(MAX_PAY)) ? PAY_W'(MAX_PAY) : PAY_W'(rem);
  endfunction

  always_comb begin
    valid = 1'b0;
    eof   = 1'b0;
    unique case (state)
      ST_CMD: begin valid = 1'b1; eof = (cmdIdx == 3'(CMD_DWORDS - 1)); end
      ST_HDR: valid = 1'b1;
      ST_PAY: begin valid = (bufCount != 2'd0); eof = (frameLeft == PAY_W'(1)); end
      default: ;
    endcase
  end

  assign acc = valid && !txDstRdyN;
  assign pop = (state == ST_PAY) && acc;
  assign occ = {1'b0, bufCount} + {2'b00, inflight};

  assign fifoRdEn = (state == ST_HDR || state == ST_PAY) && (reqLeft != '0) && !fifoEmpty
                    && (occ < 3'd2 || (occ == 3'd2 && pop));

  assign strb.latchCmd = (state == ST_IDLE) && sendCmd;
  assign strb.srcSel   = (state == ST_CMD) ? SRC_CMD : (state == ST_HDR) ? SRC_HDR : SRC_PAY;
  assign strb.cmdIdx   = cmdIdx;
  assign strb.push     = inflight;
  assign strb.pop      = pop;

  assign txSrcRdyN = !valid;
  assign txEofN    = !(valid && eof);
  assign busy      = (state != ST_IDLE);
  assign done      = doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cmdIdx    <= '0;
      totLeft   <= '0;
      frameLeft <= '0;
      reqLeft   <= '0;
      inflight  <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      doneQ    <= 1'b0;
      inflight <= fifoRdEn;
      if (fifoRdEn) reqLeft <= reqLeft - PAY_W'(1);
      unique case (state)
        ST_IDLE: begin
          if (sendCmd) begin
            state  <= ST_CMD;
            cmdIdx <= '0;
          end else if (sendData && dataLen != '0) begin
            frameLeft <= frameSize(dataLen);
            reqLeft   <= frameSize(dataLen);
            totLeft   <= dataLen - LEN_W'(frameSize(dataLen));
            state     <= ST_HDR;
          end
        end
        ST_CMD: begin
          if (acc) begin
            if (eof) begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end else cmdIdx <= cmdIdx + 3'd1;
          end
        end
        ST_HDR: if (acc) state <= ST_PAY;
        default: begin
          if (pop) begin
            frameLeft <= frameLeft - PAY_W'(1);
            if (eof) begin
              if (totLeft == '0) begin
                state <= ST_IDLE;
                doneQ <= 1'b1;
              end else begin
                state     <= ST_HDR;
                frameLeft <= frameSize(totLeft);
                reqLeft   <= frameSize(totLeft);
                totLeft   <= totLeft - LEN_W'(frameSize(totLeft));
              end
            end
          end
        end
      endcase
    end
  end

  // R7: the FIFO is never read while it reports empty
  assert_rden_not_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    fifoRdEn |-> !fifoEmpty);
  // R9: completion follows acceptance of a final dword
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(!txEofN && !txDstRdyN));
  // R9: no request is taken while a job runs
  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && !(acc && eof && (state == ST_CMD || totLeft == '0))) |=> busy);

endmodule

// File: rtl/fis_tx_framer.sv
module fis_tx_framer
  import fis_tx_pkg::*;
#(
  parameter int MAX_PAY = 2048,
  parameter int LEN_W   = 24
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sendCmd,
  input  logic [1:0]       cmdOp,
  input  logic [47:0]      cmdLba,
  input  logic [15:0]      cmdCount,
  input  logic             sendData,
  input  logic [LEN_W-1:0] dataLen,
  output logic             busy,
  output logic             done,
  input  logic             fifoEmpty,
  output logic             fifoRdEn,
  input  logic [31:0]      fifoRdData,
  output logic [31:0]      txData,
  output logic             txEofN,
  output logic             txSrcRdyN,
  output logic             txSrcDscN,
  input  logic             txDstRdyN
);

  ctrlStrobes_t strb;
  logic [1:0]   bufCount;

  assign txSrcDscN = 1'b1;

  fis_tx_ctrl #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sendCmd(sendCmd), .sendData(sendData),
    .dataLen(dataLen), .fifoEmpty(fifoEmpty), .txDstRdyN(txDstRdyN),
    .bufCount(bufCount), .strb(strb), .fifoRdEn(fifoRdEn),
    .txSrcRdyN(txSrcRdyN), .txEofN(txEofN), .busy(busy), .done(done)
  );

  fis_tx_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdOp(cmdOp), .cmdLba(cmdLba),
    .cmdCount(cmdCount), .fifoRdData(fifoRdData), .txData(txData),
    .bufCount(bufCount)
  );

  // R8: a stalled dword and its strobes are held
  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!txSrcRdyN && txDstRdyN) |=> (!txSrcRdyN && $stable(txData) && $stable(txEofN)));
  // R6: end of frame only marks a valid dword
  assert_eof_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    !txEofN |-> !txSrcRdyN);
  // R2: abort output stays inactive
  assert_abort_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    txSrcDscN);

endmodule

// File: tb/fis_tx_framer_tb_top.sv
module fis_tx_framer_tb_top;

  localparam int MAX_PAY = 4;
  localparam int LEN_W   = 24;
  localparam logic [31:0] VBASE = 32'hC0DE_0000;

  // op[81:80] lba[79:32] cnt[31:16] len[15:8] emptyLvl[7:4] stallLvl[3:0]
  localparam logic [81:0] VECS [8] = '{
    {2'd2, 48'h0000_0000_1000, 16'd1,      8'd3,  4'd0,  4'd0},
    {2'd2, 48'h1234_5678_9ABC, 16'd2,      8'd4,  4'd0,  4'd0},
    {2'd2, 48'h0000_00FF_0000, 16'd9,      8'd9,  4'd6,  4'd0},
    {2'd3, 48'hA5A5_0000_5A5A, 16'd8,      8'd8,  4'd0,  4'd7},
    {2'd0, 48'h0000_0000_0000, 16'd0,      8'd5,  4'd5,  4'd5},
    {2'd1, 48'h0000_0000_0000, 16'd0,      8'd1,  4'd9,  4'd9},
    {2'd2, 48'h0F0E_0D0C_0B0A, 16'hFFFF,   8'd12, 4'd11, 4'd10},
    {2'd3, 48'hFFFF_FFFF_FFFF, 16'h8000,   8'd2,  4'd3,  4'd12}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sendCmd = 1'b0, sendData = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [47:0] cmdLba = '0;
  logic [15:0] cmdCount = '0;
  logic [LEN_W-1:0] dataLen = '0;
  logic busy, done, fifoRdEn, txEofN, txSrcRdyN, txSrcDscN;
  logic fifoEmpty = 1'b1, txDstRdyN = 1'b0;
  logic [31:0] fifoRdData = '0, txData;

  always #2 clk = ~clk;

  fis_tx_framer #(.MAX_PAY(MAX_PAY), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rstN(rstN), .sendCmd(sendCmd), .cmdOp(cmdOp), .cmdLba(cmdLba),
    .cmdCount(cmdCount), .sendData(sendData), .dataLen(dataLen), .busy(busy),
    .done(done), .fifoEmpty(fifoEmpty), .fifoRdEn(fifoRdEn), .fifoRdData(fifoRdData),
    .txData(txData), .txEofN(txEofN), .txSrcRdyN(txSrcRdyN), .txSrcDscN(txSrcDscN),
    .txDstRdyN(txDstRdyN)
  );

  // expected stream, written by the stimulus, read by the monitor
  logic [31:0] expD [64];
  logic        expE [64];
  int          expK [64];
  int expN = 0, baseGot = 0, supplyLim = 0;
  logic [3:0] eLvl = '0, sLvl = '0;
  logic monIgnore = 1'b0;

  // FIFO model with one-cycle read latency
  int popped = 0;
  always @(posedge clk) begin
    if (fifoRdEn) begin
      fifoRdData <= VBASE + 32'(popped);
      popped     <= popped + 1;
    end
  end

  // watchdog
  int cyc = 0;
  logic timedOut = 1'b0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) timedOut <= 1'b1;
  end

  // input randomiser and monitor
  int mChk = 0, mBad = 0, gotN = 0, doneCnt = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic held = 1'b0, heldE = 1'b1, lastFin = 1'b0;
  logic [31:0] heldD = '0;
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    fifoEmpty = (popped >= supplyLim) || (lfsr[3:0] < eLvl);
    txDstRdyN = (lfsr[11:8] < sLvl);
    #1;
    if (!rstN) begin
      held = 1'b0;
      lastFin = 1'b0;
    end else begin
      if (fifoRdEn && fifoEmpty) begin
        mChk++; mBad++;
        $display("FAIL R7 read while empty: rdEn=%b exp 0", fifoRdEn);
      end
      if (held) begin
        mChk++;
        if (txSrcRdyN || txData !== heldD || txEofN !== heldE) begin
          mBad++;
          $display("FAIL R8 stalled dword changed: %h/%b exp %h/%b", txData, txEofN, heldD, heldE);
        end
      end
      held  = !txSrcRdyN && txDstRdyN;
      heldD = txData;
      heldE = txEofN;
      if (done) begin
        doneCnt++;
        mChk++;
        if (!lastFin) begin
          mBad++;
          $display("FAIL R9 done without final accept: done=%b exp 0", done);
        end
      end
      lastFin = !txSrcRdyN && !txDstRdyN && !txEofN;
      if (!txSrcRdyN && !txDstRdyN) begin
        if (!monIgnore) begin
          mChk++;
          if (gotN - baseGot >= expN) begin
            mBad++;
            $display("FAIL R5 extra dword %h exp none", txData);
          end else if (txData !== expD[gotN - baseGot]) begin
            mBad++;
            if (expK[gotN - baseGot] == 0)
              $display("FAIL R3 cmd dword %0d: %h exp %h", gotN - baseGot, txData, expD[gotN - baseGot]);
            else
              $display("FAIL R4 data dword %0d: %h exp %h", gotN - baseGot, txData, expD[gotN - baseGot]);
          end else if (txEofN !== !expE[gotN - baseGot]) begin
            mBad++;
            $display("FAIL R6 eofN at dword %0d: %b exp %b", gotN - baseGot, txEofN, !expE[gotN - baseGot]);
          end
        end
        gotN++;
      end
    end
  end

  int chk = 0, bad = 0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    chk++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  task automatic buildCmd(input logic [1:0] op, input logic [47:0] lba, input logic [15:0] cnt);
    logic [7:0] opc;
    case (op)
      2'd0: opc = 8'hEC;
      2'd1: opc = 8'hF4;
      2'd2: opc = 8'h35;
      default: opc = 8'h25;
    endcase
    expD[0] = {8'h00, opc, 8'h80, 8'h27};
    expD[1] = {8'h40, lba[23:0]};
    expD[2] = {8'h00, lba[47:24]};
    expD[3] = {16'h0000, cnt};
    expD[4] = 32'h0;
    for (int k = 0; k < 5; k++) begin
      expE[k] = (k == 4);
      expK[k] = 0;
    end
    expN = 5;
  endtask

  task automatic buildData(input int len, input int startPop);
    int n = 0, rem = len, v = startPop;
    while (rem > 0) begin
      int fl = (rem > MAX_PAY) ? MAX_PAY : rem;
      expD[n] = 32'h0000_0046; expE[n] = 1'b0; expK[n] = 1; n++;
      for (int k = 0; k < fl; k++) begin
        expD[n] = VBASE + 32'(v); expE[n] = (k == fl - 1); expK[n] = 2; n++; v++;
      end
      rem -= fl;
    end
    expN = n;
  endtask

  task automatic waitDone(input int n0);
    do begin @(negedge clk); #1; end while (doneCnt == n0 && !timedOut);
  endtask

  task automatic runVector(input int i);
    logic [81:0] v = VECS[i];
    int len = int'(v[15:8]);
    int n0;
    eLvl = v[7:4];
    sLvl = v[3:0];
    buildCmd(v[81:80], v[79:32], v[31:16]);
    baseGot = gotN;
    n0 = doneCnt;
    @(negedge clk);
    sendCmd = 1'b1; cmdOp = v[81:80]; cmdLba = v[79:32]; cmdCount = v[31:16];
    @(negedge clk);
    sendCmd = 1'b0;
    #1;
    check(busy === 1'b1, "R9 busy after command request", 32'(busy), 32'd1);
    waitDone(n0);
    check(gotN - baseGot == 5, "R3 command dword count", 32'(gotN - baseGot), 32'd5);
    check(doneCnt == n0 + 1, "R9 one done per command", 32'(doneCnt - n0), 32'd1);
    // data phase, with a command request thrown in while busy (R9)
    buildData(len, popped);
    baseGot = gotN;
    n0 = doneCnt;
    supplyLim = popped + len;
    @(negedge clk);
    sendData = 1'b1; dataLen = LEN_W'(len);
    @(negedge clk);
    sendData = 1'b0; sendCmd = 1'b1;
    @(negedge clk);
    sendCmd = 1'b0;
    waitDone(n0);
    check(gotN - baseGot == expN, "R5 dwords in data phase", 32'(gotN - baseGot), 32'(expN));
    check(doneCnt == n0 + 1, "R9 one done per data phase", 32'(doneCnt - n0), 32'd1);
  endtask

  initial begin
    // R1, R2: reset state
    repeat (3) @(negedge clk);
    #1;
    check(busy === 1'b0 && done === 1'b0, "R1 idle in reset", {30'd0, busy, done}, 32'd0);
    check(txSrcRdyN === 1'b1 && txEofN === 1'b1, "R1 strobes in reset", {30'd0, txSrcRdyN, txEofN}, 32'd3);
    check(fifoRdEn === 1'b0, "R1 no read in reset", 32'(fifoRdEn), 32'd0);
    check(txSrcDscN === 1'b1, "R2 abort inactive", 32'(txSrcDscN), 32'd1);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < 8; i++) if (!timedOut) runVector(i);

    // R10: zero length is ignored
    eLvl = '0; sLvl = '0;
    baseGot = gotN;
    @(negedge clk);
    sendData = 1'b1; dataLen = '0;
    @(negedge clk);
    sendData = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(busy === 1'b0 && txSrcRdyN === 1'b1, "R10 zero length ignored", {30'd0, busy, txSrcRdyN}, 32'd1);
    check(gotN == baseGot, "R10 no dword for zero length", 32'(gotN - baseGot), 32'd0);

    // R10: command wins over data when both requested together
    begin
      int n0 = doneCnt;
      buildCmd(2'd3, 48'h0000_1111_2222, 16'd7);
      baseGot = gotN;
      supplyLim = popped + 3;
      @(negedge clk);
      sendCmd = 1'b1; sendData = 1'b1; dataLen = LEN_W'(3);
      cmdOp = 2'd3; cmdLba = 48'h0000_1111_2222; cmdCount = 16'd7;
      @(negedge clk);
      sendCmd = 1'b0; sendData = 1'b0;
      waitDone(n0);
      repeat (10) @(negedge clk);
      #1;
      check(gotN - baseGot == 5, "R10 only command frame sent", 32'(gotN - baseGot), 32'd5);
      check(busy === 1'b0, "R10 idle after command", 32'(busy), 32'd0);
      supplyLim = popped;
    end

    // R1: reset in the middle of a data phase
    monIgnore = 1'b1;
    sLvl = 4'd4;
    supplyLim = popped + 8;
    @(negedge clk);
    sendData = 1'b1; dataLen = LEN_W'(8);
    @(negedge clk);
    sendData = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    #1;
    check(busy === 1'b0 && fifoRdEn === 1'b0, "R1 reset mid-stream", {30'd0, busy, fifoRdEn}, 32'd0);
    check(txSrcRdyN === 1'b1 && txEofN === 1'b1, "R1 strobes after reset", {30'd0, txSrcRdyN, txEofN}, 32'd3);
    supplyLim = popped;
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(busy === 1'b0 && txSrcRdyN === 1'b1, "R1 idle after reset release", {30'd0, busy, txSrcRdyN}, 32'd1);
    monIgnore = 1'b0;

    if (timedOut) begin
      chk++; bad++;
      $display("FAIL watchdog: cycles %0d exp below 150000", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", chk + mChk, bad + mBad);
    $finish;
  end

endmodule